// File: doc/BRIEF.md
# Coalescing Block-Grain Store Buffer

This block holds retired stores for a core that keeps stores ordered only across explicit barriers. Each slot covers one whole cache block and keeps a per-byte valid mask, so several stores to the same block fold into a single slot. A slot leaves toward the cache as soon as the write permission for its block has been granted, whatever older slots are still waiting. Loads look up the buffer by block address and receive, byte by byte, the newest buffered value.

A store-store barrier opens a new epoch. Slots from a later epoch may not write while any slot from an earlier epoch is still held. A store never merges into a slot from an earlier epoch. An atomic read-modify-write or a full barrier waits for the buffer to become empty. When every slot is taken and the store cannot merge, the buffer pushes back on retirement.

Top module: `blk_store_buffer`

## Requirements
- R1: An accepted store whose block matches a held slot of the current epoch merges into that slot. The slot's mask becomes the OR of both masks, and the new bytes replace the old ones. No slot is taken.
- R2: An accepted store with no matching current-epoch slot takes the lowest-numbered free slot, in the current epoch, with its permission clear. This also applies when the block is held by an earlier-epoch slot. The data bytes outside the store's mask are stored as zero.
- R3: A cycle with `fill_valid` high grants permission to every slot that held `fill_blk` before that clock edge. A slot taken in that same cycle gets no permission. A granted slot in the oldest outstanding epoch drives `wr_valid`, `wr_blk`, `wr_be` and `wr_data` in the cycle after the grant, independent of the age of other slots. It is freed at the end of that cycle.
- R4: Only slots in the oldest outstanding epoch may write, and at most one write happens per cycle. Among eligible slots, the lowest-numbered one writes. A slot that receives a merging store in a cycle does not write in that cycle.
- R5: `ld_hit[b]` is 1 when some held slot for `ld_blk` has byte b valid. `ld_data` byte b comes from the slot of the latest epoch among those. Bytes that are not hit read as zero.
- R6: A barrier is accepted when `ssb_req` and `ssb_ready` are both high, and it then advances the current epoch. `ssb_ready` is low while three epochs newer than the oldest outstanding one exist. A store accepted in the same cycle as a barrier belongs to the epoch before the barrier. The oldest outstanding epoch advances by one at a clock edge when it is behind the current epoch and holds no slot.
- R7: `fence_done` is high exactly when `fence_req` is high and no slot is held.
- R8: `st_ready` is low exactly when every slot is held and no slot of the current epoch matches `st_blk`.
- R9: After reset no slot is held, both epoch counters are zero, `wr_valid` is low, and `st_ready` and `ssb_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Retired store offered |
| st_blk | input | ADDR_W-log2(BLK_BYTES) | Block address of the store |
| st_be | input | BLK_BYTES | Byte mask of the store |
| st_data | input | 8*BLK_BYTES | Store data, byte b at bits 8b+7:8b |
| st_ready | output | 1 | Store can be accepted this cycle |
| ssb_req | input | 1 | Store-store barrier request |
| ssb_ready | output | 1 | Barrier can be accepted this cycle |
| fence_req | input | 1 | RMW or full barrier waiting for drain |
| fence_done | output | 1 | Buffer empty while fence is requested |
| fill_valid | input | 1 | Write permission granted for a block |
| fill_blk | input | ADDR_W-log2(BLK_BYTES) | Block address of the grant |
| ld_blk | input | ADDR_W-log2(BLK_BYTES) | Block address of the load lookup |
| ld_hit | output | BLK_BYTES | Bytes found in the buffer |
| ld_data | output | 8*BLK_BYTES | Forwarded bytes |
| wr_valid | output | 1 | Slot writing to the cache this cycle |
| wr_blk | output | ADDR_W-log2(BLK_BYTES) | Block address written |
| wr_be | output | BLK_BYTES | Byte mask written |
| wr_data | output | 8*BLK_BYTES | Data written, zero outside the mask |

## Verification
The hardest case to reach is a block that is held in several epochs at once while the epoch window is full. In that state a grant has to permit all of those slots, and they must then leave strictly one epoch after another. A second hard case is a merging store that lands on a slot in the same cycle the slot would otherwise write. Directed sequences first build each of these cases on purpose. These include the same block stored on both sides of a barrier, three barriers stacked behind one held slot, and a buffer filled to capacity. A long random phase then works over a pool of only six blocks, with frequent barriers and grants, so that cross-epoch duplicates, merges onto eligible slots and back-pressure keep happening. Every cycle is compared against a behavioural model.

// File: rtl/sbuf_pkg.sv
// Package: shared types for the coalescing store buffer.
// Assumes a 2-bit epoch tag, so at most four epochs are outstanding.
package sbuf_pkg;
    localparam int EPOCH_W = 2;
    typedef logic [EPOCH_W-1:0] epoch_t;
endpackage

// File: rtl/sb_slot_pick.sv
// Module: fixed-priority picker, lowest set request bit wins.
// Produces a one-hot grant, its index and an any flag. Purely combinational.
module sb_slot_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0]         req,
    output logic [N-1:0]         gnt,
    output logic [$clog2(N)-1:0] idx,
    output logic                 any
);
    localparam int IDX_W = $clog2(N);

    // Scan from the top so that the lowest requester is the last one written.
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IDX_W'(i);
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sb_forward.sv
// Module: store-to-load forwarding network.
// For each byte it picks the held slot of the latest epoch that covers the byte.
// Assumes at most one held slot per block per epoch, so ages never tie.
module sb_forward
    import sbuf_pkg::*;
#(
    parameter int N         = 8,
    parameter int BLK_W     = 26,
    parameter int BLK_BYTES = 64
) (
    input  logic [N-1:0]                  vld,
    input  logic [N-1:0][BLK_W-1:0]       blk,
    input  logic [N-1:0][BLK_BYTES-1:0]   be,
    input  logic [N-1:0][BLK_BYTES*8-1:0] data,
    input  epoch_t [N-1:0]                age,
    input  logic [BLK_W-1:0]              ld_blk,
    output logic [BLK_BYTES-1:0]          hit,
    output logic [BLK_BYTES*8-1:0]        hit_data
);
    localparam int NUM_AGES = 1 << EPOCH_W;

    // Overlay slots from oldest to youngest age, so a younger byte wins.
    always_comb begin
        hit      = '0;
        hit_data = '0;
        for (int a = 0; a < NUM_AGES; a++) begin
            for (int e = 0; e < N; e++) begin
                if (vld[e] && blk[e] == ld_blk && age[e] == epoch_t'(a)) begin
                    for (int b = 0; b < BLK_BYTES; b++) begin
                        if (be[e][b]) begin
                            hit[b]            = 1'b1;
                            hit_data[b*8 +: 8] = data[e][b*8 +: 8];
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/blk_store_buffer.sv
// Module: post-retirement store buffer with block-sized, coalescing slots.
// Slots retire in any order once their block's write permission is granted,
// restricted to the oldest outstanding barrier epoch. Assumes the cache takes
// one write per cycle without stalling, and that each grant is for a block held
// in the buffer at the time it arrives.
module blk_store_buffer
    import sbuf_pkg::*;
#(
    parameter int NUM_ENT   = 8,
    parameter int BLK_BYTES = 64,
    parameter int ADDR_W    = 32
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  st_valid,
    input  logic [ADDR_W-$clog2(BLK_BYTES)-1:0]   st_blk,
    input  logic [BLK_BYTES-1:0]                  st_be,
    input  logic [BLK_BYTES*8-1:0]                st_data,
    output logic                                  st_ready,
    input  logic                                  ssb_req,
    output logic                                  ssb_ready,
    input  logic                                  fence_req,
    output logic                                  fence_done,
    input  logic                                  fill_valid,
    input  logic [ADDR_W-$clog2(BLK_BYTES)-1:0]   fill_blk,
    input  logic [ADDR_W-$clog2(BLK_BYTES)-1:0]   ld_blk,
    output logic [BLK_BYTES-1:0]                  ld_hit,
    output logic [BLK_BYTES*8-1:0]                ld_data,
    output logic                                  wr_valid,
    output logic [ADDR_W-$clog2(BLK_BYTES)-1:0]   wr_blk,
    output logic [BLK_BYTES-1:0]                  wr_be,
    output logic [BLK_BYTES*8-1:0]                wr_data
);
    localparam int OFF_W  = $clog2(BLK_BYTES);
    localparam int BLK_W  = ADDR_W - OFF_W;
    localparam int DATA_W = BLK_BYTES * 8;
    localparam int IDX_W  = $clog2(NUM_ENT);

    // Slot state
    logic   [NUM_ENT-1:0]             ent_vld;
    logic   [NUM_ENT-1:0]             ent_perm;
    logic   [NUM_ENT-1:0][BLK_W-1:0]  ent_blk;
    logic   [NUM_ENT-1:0][BLK_BYTES-1:0] ent_be;
    logic   [NUM_ENT-1:0][DATA_W-1:0] ent_data;
    epoch_t [NUM_ENT-1:0]             ent_ep;
    epoch_t [NUM_ENT-1:0]             ent_age;
    epoch_t                           cur_ep;
    epoch_t                           old_ep;

    // Per-slot match vectors
    logic [NUM_ENT-1:0] st_hit_vec;
    logic [NUM_ENT-1:0] fill_hit_vec;
    logic [NUM_ENT-1:0] old_vec;
    logic [NUM_ENT-1:0] coal_vec;
    logic [NUM_ENT-1:0] wr_cand;
    logic [NUM_ENT-1:0] wr_oh;
    logic [NUM_ENT-1:0] free_oh;
    logic [NUM_ENT-1:0] alloc_oh;
    logic [IDX_W-1:0]   wr_idx;
    logic [IDX_W-1:0]   free_idx;
    logic               free_any;
    logic               st_hit;
    logic               st_acc;
    logic               alloc_en;
    logic               ssb_acc;

    // One comparator set per slot.
    for (genvar i = 0; i < NUM_ENT; i++) begin : g_slot
        assign st_hit_vec[i]   = ent_vld[i] && ent_blk[i] == st_blk && ent_ep[i] == cur_ep;
        assign fill_hit_vec[i] = fill_valid && ent_vld[i] && ent_blk[i] == fill_blk;
        assign old_vec[i]      = ent_vld[i] && ent_ep[i] == old_ep;
        assign ent_age[i]      = epoch_t'(ent_ep[i] - old_ep);
    end

    // Store acceptance: merge into a current-epoch slot, else need a free slot.
    assign st_hit   = |st_hit_vec;
    assign st_ready = st_hit || !(&ent_vld);
    assign st_acc   = st_valid && st_ready;
    assign coal_vec = st_acc ? st_hit_vec : '0;
    assign alloc_en = st_acc && !st_hit;
    assign alloc_oh = alloc_en ? free_oh : '0;

    // Barrier acceptance: keep the epoch window from aliasing.
    assign ssb_ready  = (cur_ep + epoch_t'(1)) != old_ep;
    assign ssb_acc    = ssb_req && ssb_ready;
    assign fence_done = fence_req && !(|ent_vld);

    // Eligible writers: granted, oldest epoch, not being merged into.
    assign wr_cand = ent_vld & ent_perm & old_vec & ~coal_vec;

    sb_slot_pick #(.N(NUM_ENT)) u_wr_pick (
        .req (wr_cand),
        .gnt (wr_oh),
        .idx (wr_idx),
        .any (wr_valid)
    );

    sb_slot_pick #(.N(NUM_ENT)) u_free_pick (
        .req (~ent_vld),
        .gnt (free_oh),
        .idx (free_idx),
        .any (free_any)
    );

    assign wr_blk  = ent_blk[wr_idx];
    assign wr_be   = ent_be[wr_idx];
    assign wr_data = ent_data[wr_idx];

    sb_forward #(.N(NUM_ENT), .BLK_W(BLK_W), .BLK_BYTES(BLK_BYTES)) u_fwd (
        .vld      (ent_vld),
        .blk      (ent_blk),
        .be       (ent_be),
        .data     (ent_data),
        .age      (ent_age),
        .ld_blk   (ld_blk),
        .hit      (ld_hit),
        .hit_data (ld_data)
    );

    // Slot occupancy and permission bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld  <= '0;
            ent_perm <= '0;
        end else begin
            for (int i = 0; i < NUM_ENT; i++) begin
                if (wr_oh[i]) begin
                    ent_vld[i]  <= 1'b0;
                    ent_perm[i] <= 1'b0;
                end else if (alloc_oh[i]) begin
                    ent_vld[i]  <= 1'b1;
                    ent_perm[i] <= 1'b0;
                end else if (fill_hit_vec[i]) begin
                    ent_perm[i] <= 1'b1;
                end
            end
        end
    end

    // Slot payload: block, epoch, mask and bytes on allocate or merge.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_ENT; i++) begin
            if (alloc_oh[i]) begin
                ent_blk[i] <= st_blk;
                ent_ep[i]  <= cur_ep;
                ent_be[i]  <= st_be;
            end else if (coal_vec[i]) begin
                ent_be[i]  <= ent_be[i] | st_be;
            end
            for (int b = 0; b < BLK_BYTES; b++) begin
                if (alloc_oh[i]) begin
                    ent_data[i][b*8 +: 8] <= st_be[b] ? st_data[b*8 +: 8] : 8'h00;
                end else if (coal_vec[i] && st_be[b]) begin
                    ent_data[i][b*8 +: 8] <= st_data[b*8 +: 8];
                end
            end
        end
    end

    // Epoch counters: barrier opens a new epoch, the oldest retires when empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ep <= '0;
            old_ep <= '0;
        end else begin
            if (ssb_acc) begin
                cur_ep <= cur_ep + epoch_t'(1);
            end
            if (old_ep != cur_ep && !(|old_vec)) begin
                old_ep <= old_ep + epoch_t'(1);
            end
        end
    end

    logic unused_free;
    assign unused_free = free_any ^ (|free_idx);
endmodule

// File: rtl/sb_checker.sv
// Module: assertion checker for the coalescing store buffer, bound to the top.
// Observes slot state and ports; drives nothing.
module sb_checker #(
    parameter int NUM_ENT = 8,
    parameter int BLK_W   = 26,
    parameter int EPOCH_W = 2
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_ENT-1:0]              ent_vld,
    input logic [NUM_ENT-1:0]              ent_perm,
    input logic [NUM_ENT-1:0][BLK_W-1:0]   ent_blk,
    input logic [NUM_ENT-1:0][EPOCH_W-1:0] ent_ep,
    input logic [EPOCH_W-1:0]              cur_ep,
    input logic [EPOCH_W-1:0]              old_ep,
    input logic                            st_valid,
    input logic                            st_ready,
    input logic                            ssb_req,
    input logic                            ssb_ready,
    input logic                            fence_req,
    input logic                            fence_done,
    input logic                            wr_valid,
    input logic [BLK_W-1:0]                wr_blk
);
    logic [7:0] dup_cnt;
    logic       wr_src_ok;

    // Count pairs of held slots sharing block and epoch.
    always_comb begin
        dup_cnt = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            for (int j = i + 1; j < NUM_ENT; j++) begin
                if (ent_vld[i] && ent_vld[j] && ent_blk[i] == ent_blk[j] && ent_ep[i] == ent_ep[j]) begin
                    dup_cnt = dup_cnt + 8'd1;
                end
            end
        end
    end

    // Find a granted oldest-epoch slot holding the written block.
    always_comb begin
        wr_src_ok = 1'b0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (ent_vld[i] && ent_perm[i] && ent_ep[i] == old_ep && ent_blk[i] == wr_blk) begin
                wr_src_ok = 1'b1;
            end
        end
    end

    a_r1_one_slot_per_epoch: assert property (@(posedge clk) disable iff (!rst_n)
        dup_cnt == 8'd0);

    a_r4_write_oldest_epoch: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_src_ok);

    a_r6_barrier_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ssb_req && !ssb_ready) |=> $stable(cur_ep));

    a_r7_fence_waits_write: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_req && wr_valid) |-> !fence_done);

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |-> (&ent_vld));
endmodule

bind blk_store_buffer sb_checker #(
    .NUM_ENT (NUM_ENT),
    .BLK_W   (BLK_W),
    .EPOCH_W (sbuf_pkg::EPOCH_W)
) u_sb_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ent_vld    (ent_vld),
    .ent_perm   (ent_perm),
    .ent_blk    (ent_blk),
    .ent_ep     (ent_ep),
    .cur_ep     (cur_ep),
    .old_ep     (old_ep),
    .st_valid   (st_valid),
    .st_ready   (st_ready),
    .ssb_req    (ssb_req),
    .ssb_ready  (ssb_ready),
    .fence_req  (fence_req),
    .fence_done (fence_done),
    .wr_valid   (wr_valid),
    .wr_blk     (wr_blk)
);

// File: tb/blk_store_buffer_bench.sv
`timescale 1ns/100ps
// Bench: behavioural slot model compared against the buffer on every clock.
module blk_store_buffer_bench;
    localparam int NE = 8;
    localparam int BB = 64;
    localparam int AW = 32;
    localparam int BW = AW - $clog2(BB);
    localparam int DW = BB * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_valid = 1'b0, ssb_req = 1'b0, fence_req = 1'b0, fill_valid = 1'b0;
    logic [BW-1:0] st_blk = '0, fill_blk = '0, ld_blk = '0;
    logic [BB-1:0] st_be = '0;
    logic [DW-1:0] st_data = '0;
    logic st_ready, ssb_ready, fence_done, wr_valid;
    logic [BB-1:0] ld_hit, wr_be;
    logic [DW-1:0] ld_data, wr_data;
    logic [BW-1:0] wr_blk;

    blk_store_buffer #(.NUM_ENT(NE), .BLK_BYTES(BB), .ADDR_W(AW)) u_blk_store_buffer (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_blk(st_blk), .st_be(st_be), .st_data(st_data), .st_ready(st_ready),
        .ssb_req(ssb_req), .ssb_ready(ssb_ready),
        .fence_req(fence_req), .fence_done(fence_done),
        .fill_valid(fill_valid), .fill_blk(fill_blk),
        .ld_blk(ld_blk), .ld_hit(ld_hit), .ld_data(ld_data),
        .wr_valid(wr_valid), .wr_blk(wr_blk), .wr_be(wr_be), .wr_data(wr_data)
    );

    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // Reference model state
    bit            m_vld  [NE];
    bit            m_perm [NE];
    logic [BW-1:0] m_blk  [NE];
    logic [BB-1:0] m_be   [NE];
    logic [DW-1:0] m_data [NE];
    int            m_ep   [NE];
    int            m_cur, m_old;
    // Expectations for the current cycle
    int e_hit, e_wr;
    bit e_st_ready, e_acc, e_ssb_ready;

    task automatic model_reset();
        for (int i = 0; i < NE; i++) begin
            m_vld[i] = 0; m_perm[i] = 0; m_ep[i] = 0;
            m_blk[i] = '0; m_be[i] = '0; m_data[i] = '0;
        end
        m_cur = 0; m_old = 0;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Compute expected outputs from model state and driven inputs, then compare.
    task automatic compare();
        bit full, any_vld;
        logic [BB-1:0] x_hit;
        logic [DW-1:0] x_ld;
        int best;
        e_hit = -1; full = 1; any_vld = 0;
        for (int i = 0; i < NE; i++) begin
            if (m_vld[i] && m_blk[i] == st_blk && m_ep[i] == m_cur) e_hit = i;
            if (!m_vld[i]) full = 0;
            if (m_vld[i]) any_vld = 1;
        end
        e_st_ready  = (e_hit >= 0) || !full;
        e_acc       = st_valid && e_st_ready;
        e_ssb_ready = (m_cur - m_old) < 3;
        e_wr = -1;
        for (int i = NE - 1; i >= 0; i--)
            if (m_vld[i] && m_perm[i] && m_ep[i] == m_old && !(e_acc && e_hit == i)) e_wr = i;
        x_hit = '0; x_ld = '0;
        for (int b = 0; b < BB; b++) begin
            best = -1;
            for (int i = 0; i < NE; i++)
                if (m_vld[i] && m_blk[i] == ld_blk && m_be[i][b] && m_ep[i] > best) begin
                    best = m_ep[i]; x_hit[b] = 1'b1; x_ld[b*8 +: 8] = m_data[i][b*8 +: 8];
                end
        end
        chk(st_ready == e_st_ready, "R8 st_ready", DW'(st_ready), DW'(e_st_ready));
        chk(ssb_ready == e_ssb_ready, "R6 ssb_ready", DW'(ssb_ready), DW'(e_ssb_ready));
        chk(fence_done == (fence_req && !any_vld), "R7 fence_done", DW'(fence_done), DW'(fence_req && !any_vld));
        chk(wr_valid == (e_wr >= 0), "R4 wr_valid", DW'(wr_valid), DW'(e_wr >= 0));
        if (wr_valid && e_wr >= 0) begin
            chk(wr_blk == m_blk[e_wr], "R3 wr_blk", DW'(wr_blk), DW'(m_blk[e_wr]));
            chk(wr_be == m_be[e_wr], "R1 wr_be", DW'(wr_be), DW'(m_be[e_wr]));
            chk(wr_data == m_data[e_wr], "R2 wr_data", wr_data, m_data[e_wr]);
        end
        chk(ld_hit == x_hit, "R5 ld_hit", DW'(ld_hit), DW'(x_hit));
        chk(ld_data == x_ld, "R5 ld_data", ld_data, x_ld);
    endtask

    // Advance the model by one clock edge using this cycle's expectations.
    task automatic model_update();
        bit adv, pre_vld [NE];
        int slot;
        adv = m_old < m_cur;
        for (int i = 0; i < NE; i++) begin
            pre_vld[i] = m_vld[i];
            if (m_vld[i] && m_ep[i] == m_old) adv = 0;
        end
        for (int i = 0; i < NE; i++)
            if (fill_valid && pre_vld[i] && m_blk[i] == fill_blk) m_perm[i] = 1;
        if (e_wr >= 0) begin m_vld[e_wr] = 0; m_perm[e_wr] = 0; end
        if (e_acc && e_hit >= 0) begin
            m_be[e_hit] |= st_be;
            for (int b = 0; b < BB; b++)
                if (st_be[b]) m_data[e_hit][b*8 +: 8] = st_data[b*8 +: 8];
        end else if (e_acc) begin
            slot = -1;
            for (int i = NE - 1; i >= 0; i--) if (!pre_vld[i]) slot = i;
            m_vld[slot] = 1; m_perm[slot] = 0; m_blk[slot] = st_blk;
            m_ep[slot] = m_cur; m_be[slot] = st_be;
            for (int b = 0; b < BB; b++)
                m_data[slot][b*8 +: 8] = st_be[b] ? st_data[b*8 +: 8] : 8'h00;
        end
        if (ssb_req && e_ssb_ready) m_cur++;
        if (adv) m_old++;
    endtask

    // One clock: compare after inputs settle, update model at the edge.
    task automatic cycle();
        #1;
        compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle();
        st_valid = 0; ssb_req = 0; fill_valid = 0; fence_req = 0;
    endtask

    function automatic logic [DW-1:0] rnd_data();
        logic [DW-1:0] r;
        for (int k = 0; k < DW / 32; k++) r[k*32 +: 32] = $urandom;
        return r;
    endfunction

    task automatic put_store(input logic [BW-1:0] b, input logic [BB-1:0] m);
        idle(); st_valid = 1; st_blk = b; st_be = m; st_data = rnd_data();
        cycle();
        idle();
    endtask

    task automatic put_fill(input logic [BW-1:0] b);
        idle(); fill_valid = 1; fill_blk = b;
        cycle();
        idle();
    endtask

    task automatic wait_write(input int limit);
        for (int k = 0; k < limit && !wr_valid; k++) cycle();
        #1;
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R9 reset state
        chk(!wr_valid && st_ready && ssb_ready, "R9 reset outputs", DW'({wr_valid, st_ready, ssb_ready}), DW'(3'b011));
        ld_blk = 'h10;

        // R1 merge then write with the union mask
        put_store('h10, 64'h0F);
        put_store('h10, 64'h3C);
        #1;
        chk(ld_hit == 64'h3F, "R1 merged load mask", DW'(ld_hit), DW'(64'h3F));
        put_fill('h10);
        #1;
        chk(wr_valid && wr_be == 64'h3F, "R1 single merged write", DW'(wr_be), DW'(64'h3F));
        cycle();

        // R3 out-of-order leave on grant
        put_store('h21, 64'h1); put_store('h22, 64'h2); put_store('h23, 64'h4);
        put_fill('h23);
        #1;
        chk(wr_valid && wr_blk == 'h23, "R3 youngest granted leaves first", DW'(wr_blk), DW'('h23));
        fill_valid = 1; fill_blk = 'h21; cycle();
        fill_blk = 'h22; cycle(); idle();
        for (int k = 0; k < 4; k++) cycle();

        // R2 and R4: same block across a barrier
        ld_blk = 'h30;
        put_store('h30, 64'h0F);
        idle(); ssb_req = 1; cycle(); idle();
        put_store('h30, 64'hF0);
        #1;
        chk(ld_hit == 64'hFF, "R2 two slots both forward", DW'(ld_hit), DW'(64'hFF));
        put_fill('h30);
        #1;
        chk(wr_valid && wr_be == 64'h0F, "R4 older epoch writes first", DW'(wr_be), DW'(64'h0F));
        cycle();
        #1;
        chk(!wr_valid, "R4 younger waits for epoch advance", DW'(wr_valid), DW'(0));
        wait_write(6);
        chk(wr_valid && wr_be == 64'hF0, "R4 younger epoch writes later", DW'(wr_be), DW'(64'hF0));
        cycle();

        // R8 back-pressure when full, merge still allowed
        for (int k = 0; k < NE; k++) put_store(BW'('h40 + k), 64'h1);
        st_valid = 1; st_blk = 'h50; st_be = 64'h1; #1;
        chk(!st_ready, "R8 full stalls new block", DW'(st_ready), DW'(0));
        st_blk = 'h43; st_be = 64'h2; #1;
        chk(st_ready, "R8 full still merges", DW'(st_ready), DW'(1));
        cycle(); idle();
        fence_req = 1; #1;
        chk(!fence_done, "R7 fence waits while held", DW'(fence_done), DW'(0));
        for (int k = 0; k < NE; k++) begin
            fill_valid = 1; fill_blk = BW'('h40 + k); cycle();
        end
        fill_valid = 0;
        for (int k = 0; k < 12 && !fence_done; k++) cycle();
        #1;
        chk(fence_done, "R7 fence completes on empty", DW'(fence_done), DW'(1));
        idle();

        // R6 epoch window full
        put_store('h60, 64'h1);
        ssb_req = 1; cycle(); cycle(); cycle(); #1;
        chk(!ssb_ready, "R6 fourth barrier stalls", DW'(ssb_ready), DW'(0));
        cycle(); idle();
        put_fill('h60);
        for (int k = 0; k < 8; k++) cycle();
        #1;
        chk(ssb_ready, "R6 barrier reopens after drain", DW'(ssb_ready), DW'(1));

        // Random phase over a small block pool
        for (int n = 0; n < 3000; n++) begin
            st_valid   = ($urandom % 100) < 55;
            st_blk     = BW'('h70 + $urandom % 6);
            st_be      = {$urandom, $urandom} & {$urandom, $urandom};
            st_data    = rnd_data();
            ssb_req    = ($urandom % 100) < 12;
            fill_valid = ($urandom % 100) < 35;
            fill_blk   = BW'('h70 + $urandom % 6);
            fence_req  = ($urandom % 100) < 10;
            ld_blk     = BW'('h70 + $urandom % 6);
            cycle();
        end
        idle();
        for (int n = 0; n < 60; n++) begin
            fill_valid = 1; fill_blk = BW'('h70 + n % 6); cycle();
        end
        idle(); fence_req = 1;
        for (int k = 0; k < 20; k++) cycle();
        #1;
        chk(fence_done, "R7 buffer empty after final drain", DW'(fence_done), DW'(1));

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule